// File: doc/BRIEF.md
# USB Interrupt Status Aggregator

This block gathers the event flags of a full-speed USB controller into one interrupt status register and turns them into a single level-sensitive interrupt request. The protocol engine sends one-cycle event pulses. Each pulse sets a sticky flag. A software-written enable register decides which flags may drive the generic interrupt line. Software services the flags it cares about and clears only those, by writing zero to them. Any enabled flag it leaves set keeps the line asserted, so a new request follows automatically.

The block also summarises endpoint transaction completion. Each endpoint supplies its own pending bit and the direction of its last transaction. From these the block derives three read-only things. The first is a transaction-complete flag. The second is the index and direction of the lowest-numbered pending endpoint. The third is a dedicated endpoint interrupt line that no enable bit can suppress. The flag and the dedicated line clear only when the endpoint's own pending bit is cleared. That bit lives in the endpoint logic, outside this block.

Register layout, shared by the status and enable registers:
- bits [3:0]: endpoint index (status only)
- bit 4: direction (status only)
- bit 8: transaction-complete flag (status) or its enable (enable register)
- bits 9 and up: one bit per event

The status register sits at offset 0x44 and the enable register at offset 0x40.

Top module: `usbirq_status_agg`

## Requirements
- R1: After reset, the status register (0x44) and the enable register (0x40) read as zero, and `irq_gen` is low.
- R2: A one-cycle pulse on `evt_pulse[i]` sets status bit 9+i from the next clock edge on. The bit then stays set until software clears it.
- R3: A write to 0x44 clears each event bit whose write-data bit is 0. Event bits written with 1 keep their value.
- R4: If an event pulse arrives in the same cycle as a write that clears its bit, the bit ends up set.
- R5: `irq_gen` equals the OR over all event bits of (event bit AND enable bit 9+i), ORed with (transaction-complete flag AND enable bit 8).
- R6: When several events are pending at once, `irq_gen` is a single level. It stays high after a partial clear as long as any enabled event bit is still set, and it falls only when the last one is cleared.
- R7: Status bit 8 is 1 exactly when any bit of `ep_pend` is 1.
- R8: `irq_ep` is high exactly when any bit of `ep_pend` is 1, whatever the enable register holds.
- R9: Status bits [3:0] give the lowest-numbered pending endpoint, and bit 4 gives that endpoint's direction (1 = OUT/SETUP, 0 = IN). Both fields read 0 when nothing is pending, and they follow `ep_pend` in the same cycle.
- R10: Writes to status bits [8:0] have no effect. Those bits always reflect `ep_pend` and `ep_dir`.
- R11: The enable register reads back its written bits 8 and 9 upward, with all other bits 0. Any address other than 0x40 or 0x44 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | NUM_EVT | One-cycle event pulses from the protocol engine |
| ep_pend | input | NUM_EP | Per-endpoint transaction-complete pending bits |
| ep_dir | input | NUM_EP | Per-endpoint direction of the last transaction (1 = OUT/SETUP) |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| irq_gen | output | 1 | Generic interrupt request |
| irq_ep | output | 1 | Dedicated endpoint interrupt |

## Verification
The assertions assume two things about the inputs. First, a write strobe is a single event that lasts one clock. Second, `ep_pend` and `ep_dir` are stable, synchronous levels that change only between clock edges, so a bit can fall only after a write of zero. The stimulus drives all inputs one time unit after each rising edge. It holds the write strobe for exactly one cycle and never glitches the endpoint inputs. The sweeps then cover every pattern of pending endpoints, every enable pattern against fixed event patterns, and an event colliding with its own clear.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
   // Field positions shared by the status and enable registers
   localparam int unsigned IDX_LSB = 0;
   localparam int unsigned DIR_BIT = 4;
   localparam int unsigned CTR_BIT = 8;
   localparam int unsigned EVT_LSB = 9;

   // Default register offsets
   localparam int unsigned MASK_ADDR_DEF = 'h40;
   localparam int unsigned STAT_ADDR_DEF = 'h44;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_MASK = 2'd1,
      SEL_STAT = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/usbirq_evt_bank.sv
module usbirq_evt_bank #(
   parameter int unsigned NUM_EVT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_pulse,
   input  logic               clr_we,
   input  logic [NUM_EVT-1:0] clr_wdata,
   output logic [NUM_EVT-1:0] evt_q
);
   generate
      for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
         logic clr_req;
         assign clr_req = clr_we & ~clr_wdata[g];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               evt_q[g] <= 1'b0;
            end else begin
               // a new event always wins over a concurrent clear
               evt_q[g] <= evt_pulse[g] | (evt_q[g] & ~clr_req);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/usbirq_mask_reg.sv
module usbirq_mask_reg #(
   parameter int unsigned NUM_EVT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [NUM_EVT-1:0] wdata_evt,
   input  logic               wdata_ctr,
   output logic [NUM_EVT-1:0] en_evt,
   output logic               en_ctr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_evt <= '0;
         en_ctr <= 1'b0;
      end else if (we) begin
         en_evt <= wdata_evt;
         en_ctr <= wdata_ctr;
      end
   end
endmodule

// File: rtl/usbirq_ep_select.sv
module usbirq_ep_select #(
   parameter int unsigned NUM_EP = 8,
   parameter int unsigned IDX_W  = 4
) (
   input  logic [NUM_EP-1:0] ep_pend,
   input  logic [NUM_EP-1:0] ep_dir,
   output logic              any_pend,
   output logic [IDX_W-1:0]  sel_idx,
   output logic              sel_dir
);
   assign any_pend = |ep_pend;

   generate
      if (NUM_EP == 1) begin : g_single
         assign sel_idx = '0;
         assign sel_dir = ep_pend[0] & ep_dir[0];
      end else begin : g_scan
         always_comb begin
            sel_idx = '0;
            sel_dir = 1'b0;
            // scan downward so the lowest pending endpoint is the last to assign
            for (int k = NUM_EP - 1; k >= 0; k--) begin
               if (ep_pend[k]) begin
                  sel_idx = IDX_W'(k);
                  sel_dir = ep_dir[k];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/usbirq_status_agg.sv
module usbirq_status_agg
   import usbirq_pkg::*;
#(
   parameter int unsigned NUM_EVT   = 7,
   parameter int unsigned NUM_EP    = 8,
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned STAT_ADDR = STAT_ADDR_DEF,
   parameter int unsigned MASK_ADDR = MASK_ADDR_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_pulse,
   input  logic [NUM_EP-1:0]  ep_pend,
   input  logic [NUM_EP-1:0]  ep_dir,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_we,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq_gen,
   output logic               irq_ep
);
   localparam int unsigned EVT_MSB = EVT_LSB + NUM_EVT - 1;

   // elaboration-time parameter checks
   generate
      if (NUM_EVT < 1 || EVT_MSB >= DATA_W) begin : g_bad_evt
         $error("usbirq_status_agg: event field does not fit DATA_W");
      end
      if (NUM_EP < 1 || (NUM_EP > 1 && $clog2(NUM_EP) > IDX_W)) begin : g_bad_idx
         $error("usbirq_status_agg: IDX_W too narrow for NUM_EP");
      end
      if (IDX_W > DIR_BIT) begin : g_bad_idxw
         $error("usbirq_status_agg: index field overlaps direction bit");
      end
      if (STAT_ADDR == MASK_ADDR || STAT_ADDR >= (1 << ADDR_W) || MASK_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("usbirq_status_agg: register offsets invalid");
      end
   endgenerate

   reg_sel_e            sel;
   logic                stat_we;
   logic                mask_we;
   logic [NUM_EVT-1:0]  evt_q;
   logic [NUM_EVT-1:0]  en_evt;
   logic                en_ctr;
   logic                ctr_flag;
   logic [IDX_W-1:0]    ep_idx;
   logic                ep_sel_dir;
   logic [DATA_W-1:0]   stat_word;
   logic [DATA_W-1:0]   mask_word;

   always_comb begin
      if (reg_addr == ADDR_W'(STAT_ADDR))      sel = SEL_STAT;
      else if (reg_addr == ADDR_W'(MASK_ADDR)) sel = SEL_MASK;
      else                                     sel = SEL_NONE;
   end

   assign stat_we = reg_we && (sel == SEL_STAT);
   assign mask_we = reg_we && (sel == SEL_MASK);

   usbirq_evt_bank #(.NUM_EVT(NUM_EVT)) u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_pulse (evt_pulse),
      .clr_we    (stat_we),
      .clr_wdata (reg_wdata[EVT_MSB:EVT_LSB]),
      .evt_q     (evt_q)
   );

   usbirq_mask_reg #(.NUM_EVT(NUM_EVT)) u_mask (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (mask_we),
      .wdata_evt (reg_wdata[EVT_MSB:EVT_LSB]),
      .wdata_ctr (reg_wdata[CTR_BIT]),
      .en_evt    (en_evt),
      .en_ctr    (en_ctr)
   );

   usbirq_ep_select #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_sel (
      .ep_pend  (ep_pend),
      .ep_dir   (ep_dir),
      .any_pend (ctr_flag),
      .sel_idx  (ep_idx),
      .sel_dir  (ep_sel_dir)
   );

   always_comb begin
      stat_word                      = '0;
      stat_word[IDX_LSB +: IDX_W]    = ep_idx;
      stat_word[DIR_BIT]             = ep_sel_dir;
      stat_word[CTR_BIT]             = ctr_flag;
      stat_word[EVT_MSB:EVT_LSB]     = evt_q;
      mask_word                      = '0;
      mask_word[CTR_BIT]             = en_ctr;
      mask_word[EVT_MSB:EVT_LSB]     = en_evt;
   end

   always_comb begin
      unique case (sel)
         SEL_STAT: reg_rdata = stat_word;
         SEL_MASK: reg_rdata = mask_word;
         default:  reg_rdata = '0;
      endcase
   end

   assign irq_gen = (|(evt_q & en_evt)) | (ctr_flag & en_ctr);
   assign irq_ep  = ctr_flag;
endmodule

// File: rtl/usbirq_status_chk.sv
module usbirq_status_chk #(
   parameter int unsigned NUM_EVT = 7,
   parameter int unsigned NUM_EP  = 8,
   parameter int unsigned IDX_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_EVT-1:0] evt_pulse,
   input logic               stat_we,
   input logic [NUM_EVT-1:0] wdata_evt,
   input logic [NUM_EVT-1:0] evt_q,
   input logic [NUM_EVT-1:0] en_evt,
   input logic               en_ctr,
   input logic [NUM_EP-1:0]  ep_pend,
   input logic [IDX_W-1:0]   ep_idx,
   input logic               ctr_flag,
   input logic               irq_gen,
   input logic               irq_ep
);
   logic [NUM_EP-1:0] below_idx;
   logic              idx_hit;

   always_comb begin
      below_idx = '0;
      idx_hit   = 1'b0;
      for (int k = 0; k < NUM_EP; k++) begin
         if (IDX_W'(k) < ep_idx) below_idx[k] = 1'b1;
         if (IDX_W'(k) == ep_idx) idx_hit = ep_pend[k];
      end
   end

   // R2: every pulsed event is set one cycle later
   a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_pulse) |=> ((evt_q & $past(evt_pulse)) == $past(evt_pulse)));

   // R3: without pulse or status write the event bits hold
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_we && !(|evt_pulse)) |=> $stable(evt_q));

   // R3: a bit falls only under a write of zero to it
   a_r3_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(evt_q) & ~evt_q & ~({NUM_EVT{$past(stat_we)}} & ~$past(wdata_evt))) == '0));

   // R4: a pulse coincident with a clear still leaves the bit set
   a_r4_pulse_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && |evt_pulse) |=> ((evt_q & $past(evt_pulse)) == $past(evt_pulse)));

   // R5: generic line low means no enabled source is pending
   a_r5_no_stray_irq: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_gen |-> (((evt_q & en_evt) == '0) && !(ctr_flag && en_ctr)));

   // R8: dedicated endpoint line follows any pending endpoint
   a_r8_ep_line: assert property (@(posedge clk) disable iff (!rst_n)
      (|ep_pend) |-> (irq_ep && ctr_flag));

   // R9: reported index is pending and no lower one is
   a_r9_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (|ep_pend) |-> (idx_hit && ((ep_pend & below_idx) == '0)));
endmodule

bind usbirq_status_agg usbirq_status_chk #(
   .NUM_EVT (NUM_EVT),
   .NUM_EP  (NUM_EP),
   .IDX_W   (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_pulse (evt_pulse),
   .stat_we   (stat_we),
   .wdata_evt (reg_wdata[EVT_MSB:EVT_LSB]),
   .evt_q     (evt_q),
   .en_evt    (en_evt),
   .en_ctr    (en_ctr),
   .ep_pend   (ep_pend),
   .ep_idx    (ep_idx),
   .ctr_flag  (ctr_flag),
   .irq_gen   (irq_gen),
   .irq_ep    (irq_ep)
);

// File: tb/test_usbirq_status_agg.sv
module test_usbirq_status_agg;
   localparam int NEVT = 7;
   localparam int NEP  = 8;
   localparam logic [7:0] A_STAT = 8'h44;
   localparam logic [7:0] A_MASK = 8'h40;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NEVT-1:0] evt_pulse = '0;
   logic [NEP-1:0]  ep_pend = '0;
   logic [NEP-1:0]  ep_dir = '0;
   logic [7:0]      reg_addr = '0;
   logic            reg_we = 1'b0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic            irq_gen;
   logic            irq_ep;

   int checks = 0;
   int fails  = 0;

   logic [NEVT-1:0] m_evt = '0;
   logic [NEVT-1:0] m_en = '0;
   logic            m_en_ctr = 1'b0;

   always #4 clk = ~clk;

   usbirq_status_agg i_usbirq_status_agg (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .ep_pend(ep_pend),
      .ep_dir(ep_dir), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_gen(irq_gen), .irq_ep(irq_ep)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic pulse(input logic [NEVT-1:0] p);
      evt_pulse = p;
      tick();
      evt_pulse = '0;
   endtask

   function automatic logic [31:0] exp_stat(input logic [NEVT-1:0] e,
                                             input logic [NEP-1:0] p,
                                             input logic [NEP-1:0] d);
      logic [31:0] w = '0;
      for (int k = NEP - 1; k >= 0; k--) begin
         if (p[k]) begin
            w[3:0] = 4'(k);
            w[4]   = d[k];
         end
      end
      w[8]    = |p;
      w[15:9] = e;
      return w;
   endfunction

   function automatic logic exp_irq(input logic [NEVT-1:0] e, input logic [NEVT-1:0] en,
                                    input logic enc, input logic [NEP-1:0] p);
      return (|(e & en)) | ((|p) & enc);
   endfunction

   function automatic logic [31:0] mask_word(input logic [NEVT-1:0] en, input logic enc);
      logic [31:0] w = '0;
      w[8] = enc;
      w[15:9] = en;
      return w;
   endfunction

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) tick();
      // R1: reset state
      rd(A_STAT, d); chk("R1 status", d, 32'h0);
      rd(A_MASK, d); chk("R1 mask", d, 32'h0);
      chk("R1 irq_gen", {31'b0, irq_gen}, 32'h0);
      rst_n = 1'b1;
      tick();

      // R11: enable readback and unmapped reads
      wr(A_MASK, 32'hFFFF_FFFF);
      rd(A_MASK, d); chk("R11 mask readback", d, mask_word('1, 1'b1));
      rd(8'h10, d);  chk("R11 unmapped", d, 32'h0);
      rd(8'h48, d);  chk("R11 unmapped", d, 32'h0);
      wr(A_MASK, 32'h0);

      // R2/R3/R5: per-event set, hold, masked irq, clear
      for (int i = 0; i < NEVT; i++) begin
         pulse(NEVT'(1) << i);
         m_evt = NEVT'(1) << i;
         rd(A_STAT, d); chk("R2 set", d, exp_stat(m_evt, '0, '0));
         tick();
         rd(A_STAT, d); chk("R2 held", d, exp_stat(m_evt, '0, '0));
         chk("R5 masked off", {31'b0, irq_gen}, 32'h0);
         wr(A_MASK, mask_word(NEVT'(1) << i, 1'b0));
         chk("R5 enabled", {31'b0, irq_gen}, 32'h1);
         wr(A_STAT, 32'hFFFF_FFFF);
         rd(A_STAT, d); chk("R3 write one keeps", d, exp_stat(m_evt, '0, '0));
         wr(A_STAT, ~(32'h1 << (9 + i)));
         m_evt = '0;
         rd(A_STAT, d); chk("R3 write zero clears", d, exp_stat(m_evt, '0, '0));
         chk("R5 after clear", {31'b0, irq_gen}, 32'h0);
         wr(A_MASK, 32'h0);
      end

      // R4: pulse coinciding with a clear of the same bit
      for (int i = 0; i < NEVT; i++) begin
         evt_pulse = NEVT'(1) << i;
         reg_addr = A_STAT; reg_wdata = 32'h0; reg_we = 1'b1;
         tick();
         reg_we = 1'b0; evt_pulse = '0;
         rd(A_STAT, d); chk("R4 pulse wins", d, exp_stat(NEVT'(1) << i, '0, '0));
         wr(A_STAT, 32'h0);
      end

      // R6: single level across partial clears
      wr(A_MASK, mask_word('1, 1'b0));
      pulse('1);
      m_evt = '1;
      for (int i = 0; i < NEVT; i++) begin
         chk("R6 level before clear", {31'b0, irq_gen}, 32'h1);
         wr(A_STAT, ~(32'h1 << (9 + i)));
         m_evt[i] = 1'b0;
         chk("R6 after partial clear", {31'b0, irq_gen}, {31'b0, |m_evt});
      end

      // R5: sweep every enable pattern against two event/endpoint states
      pulse(7'b1010011);
      m_evt = 7'b1010011;
      for (int mp = 0; mp < 256; mp++) begin
         m_en = 7'(mp >> 1); m_en_ctr = mp[0];
         wr(A_MASK, mask_word(m_en, m_en_ctr));
         ep_pend = '0; #1;
         chk("R5 sweep", {31'b0, irq_gen}, {31'b0, exp_irq(m_evt, m_en, m_en_ctr, ep_pend)});
         ep_pend = 8'h20; #1;
         chk("R5 sweep ctr", {31'b0, irq_gen}, {31'b0, exp_irq(m_evt, m_en, m_en_ctr, ep_pend)});
         ep_pend = '0;
      end
      wr(A_STAT, 32'h0);
      m_evt = '0;
      wr(A_MASK, 32'h0);

      // R7/R8/R9: every pending pattern with two direction patterns, mask off
      for (int dp = 0; dp < 2; dp++) begin
         ep_dir = dp[0] ? 8'h4D : 8'hB2;
         for (int p = 0; p < 256; p++) begin
            ep_pend = 8'(p);
            rd(A_STAT, d);
            chk("R7 R9 status", d, exp_stat('0, ep_pend, ep_dir));
            chk("R8 irq_ep", {31'b0, irq_ep}, {31'b0, |ep_pend});
         end
      end

      // R10: writes to read-only fields ignored
      ep_pend = 8'h00;
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, d); chk("R10 ro ones", d, exp_stat('0, '0, ep_dir));
      ep_pend = 8'h0C;
      wr(A_STAT, 32'h0000_0000);
      rd(A_STAT, d); chk("R10 ro zeros", d, exp_stat('0, ep_pend, ep_dir));
      wr(A_STAT, 32'h0000_01FF);
      rd(A_STAT, d); chk("R10 ro mixed", d, exp_stat('0, ep_pend, ep_dir));
      ep_pend = '0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule